// File: doc/BRIEF.md
# Negate Instruction Execute Unit

This block is a one-cycle execute slice for a 32-bit register-to-register negate instruction. Each cycle it may accept an instruction word and the value already read from the source register. It decodes the word, checks that it is the negate instruction, and forms the two's complement of the operand. It then presents the result, the destination register index and a one-cycle write enable to the register file. Two optional side effects are selected by flag bits inside the word. An overflow-enable bit updates an overflow register that holds an overflow bit and a sticky summary-overflow bit. A record bit updates a 4-bit condition field that classifies the result and copies the summary-overflow bit.

Instruction bits are numbered from the most significant end, so bit 0 of the instruction is `in_instr[31]`. An instruction with neither flag set is the word 0x7C0000D0. All outputs are registered. They change on the clock edge that accepts the instruction.

Top module: `neg_exec_unit`

## Requirements
- R1: An instruction is accepted only when `in_valid` is 1 and all three of these hold: `in_instr[31:26]` = 31, `in_instr[9:1]` = 104 and the reserved field `in_instr[15:11]` = 0. If any one fails, no write is made and `res_q`, `cond_q` and `xer_q` keep their values.
- R2: On the edge that accepts an instruction, `res_q` becomes the bitwise inverse of `in_opnd` plus one. At the same edge `wr_idx_q` becomes `in_instr[25:21]`, `src_idx_q` becomes `in_instr[20:16]` and `wr_en_q` is 1 for exactly that cycle.
- R3: The overflow-enable flag is `in_instr[10]`. When it is 1, the overflow bit `xer_q[0]` becomes 1 if the operand is 0x80000000 and 0 for any other operand. When the flag is 0, `xer_q` is left unchanged.
- R4: The summary-overflow bit `xer_q[1]` is ORed with each new overflow value. Once set, it stays 1 until reset, even after later accepted instructions with overflow enabled report no overflow.
- R5: The record flag is `in_instr[0]`. When it is 1, `cond_q[3]` (negative), `cond_q[2]` (positive) and `cond_q[1]` (zero) describe the signed result, and exactly one of the three is set. When the flag is 0, `cond_q` is left unchanged.
- R6: When the record flag is 1, `cond_q[0]` receives the summary-overflow value as it stands after any update made by the same instruction.
- R7: Reset (`rst_n` low) clears `res_q`, `wr_en_q`, `wr_idx_q`, `src_idx_q`, `cond_q` and `xer_q`.
- R8: Negating 0x80000000 gives 0x80000000.
- R9: `wr_en_q` is 0 in any cycle that follows a cycle with `in_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operand are presented this cycle |
| in_instr | input | 32 | Instruction word |
| in_opnd | input | 32 | Value of the source register |
| res_q | output | 32 | Negated result |
| wr_en_q | output | 1 | Register-file write strobe, one cycle |
| wr_idx_q | output | 5 | Destination register index |
| src_idx_q | output | 5 | Source register index of the retired instruction |
| cond_q | output | 4 | Condition field {negative, positive, zero, summary overflow} |
| xer_q | output | 2 | Overflow register {summary overflow, overflow} |

## Verification
The assertions check several properties on every cycle. The write strobe lasts one cycle and never follows an idle cycle. Any written result added to the previous operand gives zero. The overflow bit matches the most negative operand. The summary bit never clears and is always set when the overflow bit is. The recorded sign bits are at most one-hot, the copied summary bit agrees with the overflow register, and both flag registers hold whenever nothing is accepted. The bench scenarios cover what the assertions cannot show. These are the exact decode boundaries: a wrong primary opcode, a wrong extended opcode, and a nonzero reserved field. They also include the ordering in which a sticky summary bit reaches later recorded condition fields, and reset clearing that sticky state in the middle of a run.

// File: rtl/neg_pkg.sv
package neg_pkg;

  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned PRIM_W    = 6;
  localparam int unsigned XO_W      = 9;
  localparam int unsigned RSV_W     = 5;

  localparam logic [PRIM_W-1:0] PRIM_NEG = 6'd31;
  localparam logic [XO_W-1:0]   XO_NEG   = 9'd104;

  // LSB-numbered positions inside the instruction word
  localparam int unsigned PRIM_LSB = 26;
  localparam int unsigned RD_LSB   = 21;
  localparam int unsigned RA_LSB   = 16;
  localparam int unsigned RSV_LSB  = 11;
  localparam int unsigned OE_POS   = 10;
  localparam int unsigned XO_LSB   = 1;
  localparam int unsigned RC_POS   = 0;

  typedef struct packed {
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] ra;
    logic                 oe;
    logic                 rc;
  } dec_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  typedef struct packed {
    logic so;
    logic ov;
  } xer_t;

endpackage

// File: rtl/neg_decode.sv
module neg_decode
  import neg_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output logic               match,
  output logic               accept,
  output dec_t               dec
);

  logic [PRIM_W-1:0] prim_f;
  logic [XO_W-1:0]   xo_f;
  logic [RSV_W-1:0]  rsv_f;
  logic              prim_ok;
  logic              xo_ok;
  logic              rsv_ok;

  assign prim_f  = instr[PRIM_LSB +: PRIM_W];
  assign xo_f    = instr[XO_LSB +: XO_W];
  assign rsv_f   = instr[RSV_LSB +: RSV_W];

  assign prim_ok = (prim_f == PRIM_NEG);
  assign xo_ok   = (xo_f == XO_NEG);
  assign rsv_ok  = (rsv_f == '0);

  assign match   = prim_ok && xo_ok && rsv_ok;
  assign accept  = valid && match;

  always_comb begin
    dec.rd = instr[RD_LSB +: REG_IDX_W];
    dec.ra = instr[RA_LSB +: REG_IDX_W];
    dec.oe = instr[OE_POS];
    dec.rc = instr[RC_POS];
  end

  always_comb begin
    if (match) begin
      a_match_fields_r1: assert (prim_f == 6'b011111 && xo_f == 9'b001101000 && rsv_f == 5'b0);
    end
  end

endmodule

// File: rtl/neg_alu.sv
module neg_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opnd,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         lt,
  output logic         gt,
  output logic         eq
);

  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] f_twos(input logic [W-1:0] a);
    return (~a) + {{(W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic f_is_min(input logic [W-1:0] a);
    return a == MIN_VAL;
  endfunction

  function automatic logic [2:0] f_sign3(input logic [W-1:0] r);
    logic z;
    z = (r == '0);
    return {r[W-1], !r[W-1] && !z, z};
  endfunction

  assign result = f_twos(opnd);
  assign ovf    = f_is_min(opnd);
  assign {lt, gt, eq} = f_sign3(result);

  always_comb begin
    a_sign_onehot_r5: assert ($onehot({lt, gt, eq}));
  end

endmodule

// File: rtl/neg_flags.sv
module neg_flags
  import neg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  oe,
  input  logic  rc,
  input  logic  ovf,
  input  logic  lt,
  input  logic  gt,
  input  logic  eq,
  output cond_t cond_q,
  output xer_t  xer_q
);

  logic so_next;
  logic ov_upd;
  logic cr_upd;

  assign ov_upd  = accept && oe;
  assign cr_upd  = accept && rc;
  assign so_next = ov_upd ? (xer_q.so | ovf) : xer_q.so;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xer_q <= '0;
    end else if (ov_upd) begin
      xer_q.ov <= ovf;
      xer_q.so <= so_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
    end else if (cr_upd) begin
      cond_q <= '{lt: lt, gt: gt, eq: eq, so: so_next};
    end
  end

  p_so_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xer_q.so) |-> xer_q.so);

  p_ov_sets_so_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xer_q.ov |-> xer_q.so);

  p_cond_so_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cr_upd) |-> (cond_q.so == xer_q.so));

  p_cond_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cr_upd) |-> $stable(cond_q));

  p_xer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ov_upd) |-> $stable(xer_q));

  p_cond_onehot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cond_q.lt, cond_q.gt, cond_q.eq}));

endmodule

// File: rtl/neg_exec_unit.sv
module neg_exec_unit
  import neg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   in_instr,
  input  logic [W-1:0]         in_opnd,
  output logic [W-1:0]         res_q,
  output logic                 wr_en_q,
  output logic [REG_IDX_W-1:0] wr_idx_q,
  output logic [REG_IDX_W-1:0] src_idx_q,
  output logic [3:0]           cond_q,
  output logic [1:0]           xer_q
);

  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

  logic         dec_match;
  logic         dec_accept;
  dec_t         dec;
  logic [W-1:0] alu_res;
  logic         alu_ovf;
  logic         alu_lt;
  logic         alu_gt;
  logic         alu_eq;
  cond_t        cond_s;
  xer_t         xer_s;

  neg_decode u_dec (
    .valid  (in_valid),
    .instr  (in_instr),
    .match  (dec_match),
    .accept (dec_accept),
    .dec    (dec)
  );

  neg_alu #(.W(W)) u_alu (
    .opnd   (in_opnd),
    .result (alu_res),
    .ovf    (alu_ovf),
    .lt     (alu_lt),
    .gt     (alu_gt),
    .eq     (alu_eq)
  );

  neg_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (dec_accept),
    .oe     (dec.oe),
    .rc     (dec.rc),
    .ovf    (alu_ovf),
    .lt     (alu_lt),
    .gt     (alu_gt),
    .eq     (alu_eq),
    .cond_q (cond_s),
    .xer_q  (xer_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= dec_accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      wr_idx_q  <= '0;
      src_idx_q <= '0;
    end else if (dec_accept) begin
      res_q     <= alu_res;
      wr_idx_q  <= dec.rd;
      src_idx_q <= dec.ra;
    end
  end

  assign cond_q = cond_s;
  assign xer_q  = xer_s;

  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q || $past(in_valid));

  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en_q);

  p_res_sum_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (res_q + $past(in_opnd)) == '0);

  p_reject_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_match) |=> !wr_en_q && $stable(res_q));

  p_ov_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec_accept && dec.oe) |-> (xer_s.ov == ($past(in_opnd) == MIN_VAL)));

  p_min_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_q && $past(in_opnd) == MIN_VAL) |-> res_q == MIN_VAL);

endmodule

// File: tb/neg_exec_unit_tb_top.sv
`timescale 1ns/1ps
module neg_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [31:0] in_opnd = '0;
  logic [31:0] res_q;
  logic        wr_en_q;
  logic [4:0]  wr_idx_q;
  logic [4:0]  src_idx_q;
  logic [3:0]  cond_q;
  logic [1:0]  xer_q;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  neg_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_opnd(in_opnd), .res_q(res_q), .wr_en_q(wr_en_q), .wr_idx_q(wr_idx_q),
    .src_idx_q(src_idx_q), .cond_q(cond_q), .xer_q(xer_q)
  );

  function automatic logic [31:0] mk(input logic [4:0] rd, input logic [4:0] ra,
                                     input logic oe, input logic rc);
    return {6'd31, rd, ra, 5'd0, oe, 9'd104, rc};
  endfunction

  localparam int NV = 8;
  localparam logic [31:0] V_INSTR [NV] = '{
    32'h7C61_00D0, 32'h7C82_00D1, 32'h7CA6_00D1, 32'h7CE7_04D0,
    32'h7D09_04D1, 32'h7FE0_04D1, 32'h7C22_04D1, 32'h7C43_00D1 };
  localparam logic [31:0] V_OPND [NV] = '{
    32'h0000_0005, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000 };
  localparam logic [31:0] V_RES [NV] = '{
    32'hFFFF_FFFB, 32'h0000_0000, 32'h0000_0001, 32'hEDCB_A988,
    32'h8000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000 };

  logic [3:0] m_cond = '0;
  logic       m_so = 1'b0;
  logic       m_ov = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ins, input logic [31:0] op);
    logic [31:0] r;
    r = ~op + 32'd1;
    if (ins[10]) begin
      m_ov = (op == 32'h8000_0000);
      m_so = m_so | m_ov;
    end
    if (ins[0]) m_cond = {r[31], !r[31] && (r != 0), r == 0, m_so};
  endtask

  // drive at negedge, capture at next posedge, sample at the following negedge
  task automatic issue(input logic [31:0] ins, input logic [31:0] op);
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_opnd = op;
    @(negedge clk);
    in_valid = 1'b0; in_instr = '0; in_opnd = '0;
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " cond"}, {28'd0, cond_q}, {28'd0, m_cond});
    chk({tag, " xer"}, {30'd0, xer_q}, {30'd0, m_so, m_ov});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R7 reset res", res_q, 32'd0);
    chk("R7 reset wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R7 reset cond", {28'd0, cond_q}, 32'd0);
    chk("R7 reset xer", {30'd0, xer_q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle wr_en", {31'd0, wr_en_q}, 32'd0);

    // vector table: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      issue(V_INSTR[i], V_OPND[i]);
      model(V_INSTR[i], V_OPND[i]);
      chk($sformatf("R2 vec%0d res", i), res_q, V_RES[i]);
      chk($sformatf("R2 vec%0d wr_en", i), {31'd0, wr_en_q}, 32'd1);
      chk($sformatf("R2 vec%0d rd", i), {27'd0, wr_idx_q}, {27'd0, V_INSTR[i][25:21]});
      chk($sformatf("R2 vec%0d ra", i), {27'd0, src_idx_q}, {27'd0, V_INSTR[i][20:16]});
      chk_flags($sformatf("R3 R5 R6 vec%0d", i));
      @(negedge clk);
      chk($sformatf("R2 vec%0d pulse", i), {31'd0, wr_en_q}, 32'd0);
    end
    chk("R8 wrap", res_q, 32'h8000_0000);
    chk("R4 sticky so", {31'd0, xer_q[1]}, 32'd1);

    // R1: rejected encodings
    held = res_q;
    issue(mk(5'd9, 5'd1, 1'b1, 1'b1) ^ 32'h0400_0000, 32'h8000_0000);
    chk("R1 bad primary wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R1 bad primary res", res_q, held);
    chk_flags("R1 bad primary");
    issue(mk(5'd9, 5'd1, 1'b1, 1'b1) ^ 32'h0000_0002, 32'h0000_0003);
    chk("R1 bad xo wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R1 bad xo res", res_q, held);
    chk_flags("R1 bad xo");
    issue(mk(5'd9, 5'd1, 1'b1, 1'b1) | 32'h0000_0800, 32'h0000_0003);
    chk("R1 reserved wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R1 reserved res", res_q, held);
    chk_flags("R1 reserved");

    // R9: operand changes without valid
    @(negedge clk);
    in_opnd = 32'h0000_0010; in_instr = mk(5'd2, 5'd2, 1'b1, 1'b1);
    @(negedge clk);
    chk("R9 no valid wr_en", {31'd0, wr_en_q}, 32'd0);
    chk("R9 no valid res", res_q, held);
    in_instr = '0; in_opnd = '0;

    // R7: reset clears sticky state mid-run, then R4 stays clear without overflow
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 mid reset xer", {30'd0, xer_q}, 32'd0);
    chk("R7 mid reset cond", {28'd0, cond_q}, 32'd0);
    chk("R7 mid reset idx", {27'd0, wr_idx_q}, 32'd0);
    rst_n = 1'b1;
    m_so = 1'b0; m_ov = 1'b0; m_cond = '0;
    issue(mk(5'd6, 5'd4, 1'b1, 1'b1), 32'hFFFF_FF00);
    model(mk(5'd6, 5'd4, 1'b1, 1'b1), 32'hFFFF_FF00);
    chk("R4 after reset res", res_q, 32'h0000_0100);
    chk_flags("R4 R6 after reset");
    issue(mk(5'd6, 5'd4, 1'b1, 1'b0), 32'h8000_0000);
    model(mk(5'd6, 5'd4, 1'b1, 1'b0), 32'h8000_0000);
    chk_flags("R3 R5 oe only");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule